// File: doc/BRIEF.md
# Frame-Aligned Clock Divider and Frame Pulse Generator

This block runs from a fast reference clock and produces a slower line-rate clock by integer division with a ratio of 2, 3, 4 or 5. The duty cycle stays at 50% for odd ratios too, measured in half periods of the fast clock. It also produces a frame pulse. The pulse repeats once per programmed number of slow-clock periods, which gives 8kHz at the usual line rates. It is centred on the slow-clock rising edge that opens a frame. Its width can be long or short, and its active level can be chosen.

An optional frame-sync input re-phases the division counter and the frame counter together. Each rising edge seen on the synchronised input forces a frame boundary. The frame-sync input can run at the frame rate or at any integer subrate of it. If the edge already lands on the internal boundary, the outputs carry on undisturbed. An input tied to either constant level never moves the phase.

All configuration inputs are expected to be stable, and a change is applied through reset. The divide ratio is valid from 2 to 5. The frame length must be at least 2.

Top module: `frame_clk_divider`

## Requirements
- R1: With `div_ratio` = N (binary value 2 to 5), `clk1_out` has a period of N fast-clock cycles, and every rising edge of `clk1_out` falls on a rising edge of `clk`.
- R2: Within each `clk1_out` period, the output is high for exactly the first N half-cycles of `clk` and low for the remaining N half-cycles. This holds for odd N as well.
- R3: The frame pulse recurs every `frame_len` periods of `clk1_out`. It is centred on the `clk1_out` rising edge that begins a frame.
- R4: With `pulse_long`=1, the pulse is active from N half-cycles of `clk` before the frame-opening edge until N half-cycles after it. That is one full `clk1_out` period.
- R5: With `pulse_long`=0, the pulse is active from floor(N/2) half-cycles before the frame-opening edge until ceil(N/2) half-cycles after it. That is half a `clk1_out` period.
- R6: With `pulse_pol`=1, `fsync_out` is high while the pulse is active and low otherwise. With `pulse_pol`=0 the levels are inverted.
- R7: While `rst` is high, `clk1_out` is low and `fsync_out` sits at its inactive level. The first `clk` rising edge with `rst` low starts a `clk1_out` high phase and frame 0. No pulse surrounds that first boundary. The first pulse is centred on the boundary that ends frame 0.
- R8: Suppose `sync_in` is low at one `clk` rising edge and high at the next one, edge E. Then the `clk` rising edge two cycles after E starts a new `clk1_out` period and a new frame, and the following frames keep this phase.
- R9: A `sync_in` rising edge whose forced boundary coincides with the natural boundary leaves both outputs unchanged. This holds for edges repeated every second frame.
- R10: A `sync_in` held at a constant level, including high across reset, causes no change of phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | 3 | Divide ratio N, 2 to 5 |
| frame_len | input | FLEN_W | Frame length in `clk1_out` periods, at least 2 |
| pulse_long | input | 1 | 1 selects the long pulse, 0 selects the short pulse |
| pulse_pol | input | 1 | 1 makes the pulse active high, 0 makes it active low |
| sync_in | input | 1 | Optional frame-sync input; rising edge forces a boundary |
| clk1_out | output | 1 | Divided clock |
| fsync_out | output | 1 | Frame pulse |

## Verification
The forced boundary from `sync_in` and the natural wrap of both counters can fall in the same cycle. The bench provokes this by timing `sync_in` edges two frames apart so that each forced boundary lands exactly on a natural one. It judges the result by comparing every half-cycle of both outputs with the undisturbed timeline, so any glitch fails. A second case fires the edge in mid-frame, where the pulse window is cut off. That case is judged on the new phase from the forced boundary onward.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int RATIO_W = 3;

  // how the rising-edge register and its falling-edge copy combine
  typedef enum logic [1:0] {SHP_A, SHP_B, SHP_AND, SHP_OR} shape_e;

  typedef struct packed {
    logic [RATIO_W-1:0] back;  // fast cycles before boundary where the rising-edge window opens
    logic [RATIO_W-1:0] fwd;   // fast cycles after boundary where it closes
    shape_e             shape;
  } pulse_cfg_t;

  function automatic shape_e clk_shape(input logic [RATIO_W-1:0] ratio);
    return ratio[0] ? SHP_OR : SHP_A;
  endfunction

  function automatic pulse_cfg_t pulse_cfg(input logic [RATIO_W-1:0] ratio,
                                           input logic long_sel);
    pulse_cfg_t c;
    if (long_sel) begin
      c.back  = (ratio + RATIO_W'(1)) >> 1;
      c.fwd   = ratio >> 1;
      c.shape = ratio[0] ? SHP_B : SHP_A;
    end else begin
      c.back = RATIO_W'(1);
      c.fwd  = (ratio > RATIO_W'(2)) ? RATIO_W'(1) : '0;
      case (ratio)
        RATIO_W'(2): c.shape = SHP_B;
        RATIO_W'(3): c.shape = SHP_AND;
        RATIO_W'(5): c.shape = SHP_OR;
        default:     c.shape = SHP_A;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/fcd_sync_edge.sv
module fcd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int PW = $clog2(STAGES + 2);
  localparam logic [PW-1:0] PRIMED = PW'(STAGES + 1);

  logic [STAGES:0] chain;
  logic [PW-1:0]   pcnt;

  // chain keeps shifting through reset so a tied level fills it
  always_ff @(posedge clk) chain <= {chain[STAGES-1:0], din};

  always_ff @(posedge clk) begin
    if (rst)                  pcnt <= '0;
    else if (pcnt != PRIMED)  pcnt <= pcnt + PW'(1);
  end

  assign rise = (pcnt == PRIMED) & chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fcd_counters.sv
module fcd_counters
  import fcd_pkg::*;
#(
  parameter int FLEN_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [FLEN_W-1:0]  flen,
  input  logic               realign,
  output logic               run_q,
  output logic [RATIO_W-1:0] d_q,
  output logic [FLEN_W-1:0]  f_q,
  output logic               arm_q,
  output logic [RATIO_W-1:0] d_nx,
  output logic [FLEN_W-1:0]  f_nx,
  output logic               arm_nx
);
  localparam logic [RATIO_W-1:0] D_ONE = RATIO_W'(1);
  localparam logic [FLEN_W-1:0]  F_ONE = FLEN_W'(1);

  always_comb begin
    d_nx = d_q;
    f_nx = f_q;
    if (!run_q || realign) begin
      d_nx = '0;
      f_nx = '0;
    end else if (d_q >= ratio - D_ONE) begin
      d_nx = '0;
      f_nx = (f_q >= flen - F_ONE) ? '0 : f_q + F_ONE;
    end else begin
      d_nx = d_q + D_ONE;
    end
    arm_nx = arm_q | (f_nx == flen - F_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      d_q   <= '0;
      f_q   <= '0;
      arm_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      d_q   <= d_nx;
      f_q   <= f_nx;
      arm_q <= arm_nx;
    end
  end
endmodule

// File: rtl/fcd_shaper.sv
module fcd_shaper
  import fcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  shape_e shape,
  input  logic   a_nx,
  output logic   a_q,
  output logic   wave
);
  logic b_q;

  always_ff @(posedge clk) begin
    if (rst) a_q <= 1'b0;
    else     a_q <= a_nx;
  end

  // half-cycle delayed copy
  always_ff @(negedge clk) begin
    if (rst) b_q <= 1'b0;
    else     b_q <= a_q;
  end

  always_comb begin
    case (shape)
      SHP_B:   wave = b_q;
      SHP_AND: wave = a_q & b_q;
      SHP_OR:  wave = a_q | b_q;
      default: wave = a_q;
    endcase
  end
endmodule

// File: rtl/frame_clk_divider.sv
module frame_clk_divider
  import fcd_pkg::*;
#(
  parameter int FLEN_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic [FLEN_W-1:0]  frame_len,
  input  logic               pulse_long,
  input  logic               pulse_pol,
  input  logic               sync_in,
  output logic               clk1_out,
  output logic               fsync_out
);
  localparam int NWAVE = 2;  // 0: divided clock, 1: frame pulse
  localparam logic [FLEN_W-1:0] F_ONE = FLEN_W'(1);

  logic               sync_rise, realign, run_q, arm_q, arm_nx;
  logic [RATIO_W-1:0] div_cnt, d_nx;
  logic [FLEN_W-1:0]  frm_cnt, f_nx;
  pulse_cfg_t         pcfg;
  logic [NWAVE-1:0]   a_nx_v, a_q_v, wave_v;
  shape_e             shp_v [NWAVE];
  logic               clk_a, fs_a;

  fcd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (sync_in), .rise (sync_rise)
  );

  assign realign = sync_rise & run_q;

  fcd_counters #(.FLEN_W(FLEN_W)) u_cnt (
    .clk (clk), .rst (rst), .ratio (div_ratio), .flen (frame_len),
    .realign (realign), .run_q (run_q), .d_q (div_cnt), .f_q (frm_cnt),
    .arm_q (arm_q), .d_nx (d_nx), .f_nx (f_nx), .arm_nx (arm_nx)
  );

  assign pcfg     = pulse_cfg(div_ratio, pulse_long);
  assign shp_v[0] = clk_shape(div_ratio);
  assign shp_v[1] = pcfg.shape;

  // rising-edge windows, loaded from the next counter state
  assign a_nx_v[0] = d_nx < (div_ratio >> 1);
  assign a_nx_v[1] = arm_nx &&
                     (((f_nx == '0) && (d_nx < pcfg.fwd)) ||
                      ((f_nx == frame_len - F_ONE) && (d_nx >= div_ratio - pcfg.back)));

  for (genvar gi = 0; gi < NWAVE; gi++) begin : g_shape
    fcd_shaper u_shp (
      .clk (clk), .rst (rst), .shape (shp_v[gi]), .a_nx (a_nx_v[gi]),
      .a_q (a_q_v[gi]), .wave (wave_v[gi])
    );
  end

  assign clk_a     = a_q_v[0];
  assign fs_a      = a_q_v[1];
  assign clk1_out  = wave_v[0];
  assign fsync_out = pulse_pol ? wave_v[1] : ~wave_v[1];
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int FLEN_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [RATIO_W-1:0] ratio,
  input logic [FLEN_W-1:0]  flen,
  input logic [RATIO_W-1:0] div_cnt,
  input logic [FLEN_W-1:0]  frm_cnt,
  input logic               realign,
  input logic               arm_q,
  input logic               clk_a,
  input logic               fs_a
);
  a_r1_rise_on_count_start: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_a) |-> (div_cnt == '0));

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (div_cnt < ratio) && (frm_cnt < flen));

  a_r3_frame_steps_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (frm_cnt != $past(frm_cnt)) |-> (div_cnt == '0));

  a_r8_realign_to_boundary: assert property (@(posedge clk) disable iff (rst)
    realign |=> ((div_cnt == '0) && (frm_cnt == '0)));

  a_r7_quiet_until_armed: assert property (@(posedge clk) disable iff (rst)
    !arm_q |-> !fs_a);
endmodule

bind frame_clk_divider fcd_checker #(.FLEN_W(FLEN_W)) u_chk (
  .clk (clk), .rst (rst), .ratio (div_ratio), .flen (frame_len),
  .div_cnt (div_cnt), .frm_cnt (frm_cnt), .realign (realign),
  .arm_q (arm_q), .clk_a (clk_a), .fs_a (fs_a)
);

// File: tb/frame_clk_divider_tb_top.sv
`timescale 1ns/1ps
module frame_clk_divider_tb_top;
  localparam int TCK    = 8;
  localparam int FLEN_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] div_ratio = 3'd2;
  logic [FLEN_W-1:0] frame_len = 10'd5;
  logic pulse_long = 1'b1, pulse_pol = 1'b1, sync_in = 1'b0;
  logic clk1_out, fsync_out;

  always #(TCK/2) clk = ~clk;

  frame_clk_divider #(.FLEN_W(FLEN_W)) dut_i (
    .clk (clk), .rst (rst), .div_ratio (div_ratio), .frame_len (frame_len),
    .pulse_long (pulse_long), .pulse_pol (pulse_pol), .sync_in (sync_in),
    .clk1_out (clk1_out), .fsync_out (fsync_out)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expectation state
  int n_cfg = 2, l_cfg = 5;
  bit long_cfg = 1'b1, pol_cfg = 1'b1, armed0 = 1'b0;
  longint ref_cyc = 0, clk_from = 64'h7fff_ffff, fs_from = 64'h7fff_ffff;
  int err_c = 0, err_f = 0;
  bit c_act, c_exp, f_act, f_exp;
  longint c_k, f_k;

  function automatic bit exp_clk(longint k);
    return (k % (2 * n_cfg)) < n_cfg;
  endfunction

  function automatic bit exp_fs(longint k);
    longint fl = 2 * n_cfg * l_cfg;
    longint fr = k / fl;
    longint hp = k % fl;
    int s = long_cfg ? n_cfg : n_cfg / 2;
    int e = long_cfg ? n_cfg : (n_cfg + 1) / 2;
    bit act = ((hp < e) && (fr >= 1 || armed0)) || (hp >= fl - s);
    return pol_cfg ? act : !act;
  endfunction

  task automatic sample(int h);
    longint k = 2 * (cyc - ref_cyc) + h;
    if (cyc >= clk_from && clk1_out !== exp_clk(k)) begin
      if (err_c == 0) begin c_act = clk1_out; c_exp = exp_clk(k); c_k = k; end
      err_c++;
    end
    if (cyc >= fs_from && fsync_out !== exp_fs(k)) begin
      if (err_f == 0) begin f_act = fsync_out; f_exp = exp_fs(k); f_k = k; end
      err_f++;
    end
  endtask

  always begin @(posedge clk); #(TCK/4); sample(0); end
  always begin @(negedge clk); #(TCK/4); sample(1); end

  task automatic check_bit(string tag, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_run(string tag_c, string tag_f);
    total++;
    if (err_c != 0) begin
      bad++;
      $display("FAIL %s clk1_out: %0d bad half-cycles, first at half %0d actual=%0b expected=%0b",
               tag_c, err_c, c_k, c_act, c_exp);
    end
    total++;
    if (err_f != 0) begin
      bad++;
      $display("FAIL %s fsync_out: %0d bad half-cycles, first at half %0d actual=%0b expected=%0b",
               tag_f, err_f, f_k, f_act, f_exp);
    end
  endtask

  task automatic do_reset(int n, int l, bit lng, bit pol);
    clk_from = 64'h7fff_ffff;
    fs_from  = 64'h7fff_ffff;
    rst = 1'b1;
    n_cfg = n; l_cfg = l; long_cfg = lng; pol_cfg = pol; armed0 = 1'b0;
    div_ratio = 3'(n); frame_len = FLEN_W'(l); pulse_long = lng; pulse_pol = pol;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    ref_cyc = cyc + 1;
    clk_from = ref_cyc;
    fs_from = ref_cyc;
    err_c = 0; err_f = 0;
  endtask

  task automatic wait_until(longint c);
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  // R7: levels held during reset
  task automatic t_reset_levels(bit pol);
    clk_from = 64'h7fff_ffff; fs_from = 64'h7fff_ffff;
    rst = 1'b1; pulse_pol = pol;
    repeat (3) @(posedge clk);
    #(TCK/4); check_bit("R7 reset clk1_out low", clk1_out, 1'b0);
    #(TCK/2); check_bit("R7 reset fsync_out inactive", fsync_out, !pol);
  endtask

  task automatic t_mode(int n, int l, bit lng, bit pol, int frames, string tc, string tf);
    do_reset(n, l, lng, pol);
    wait_until(ref_cyc + longint'(frames) * n * l + 4);
    check_run(tc, tf);
  endtask

  // R8: edge in mid-frame moves the phase
  task automatic t_realign();
    longint q;
    do_reset(3, 7, 1'b1, 1'b1);
    q = ref_cyc + 30;
    wait_until(q);
    sync_in = 1'b1;
    clk_from = q + 3; fs_from = q + 7; ref_cyc = q + 3; armed0 = 1'b1;
    repeat (3) @(posedge clk);
    #1 sync_in = 1'b0;
    wait_until(ref_cyc + 3 * 21 + 4);
    check_run("R8 realign", "R8 realign");
  endtask

  // R9: subrate edges that land on natural boundaries
  task automatic t_match();
    do_reset(4, 6, 1'b1, 1'b1);
    for (int m = 2; m <= 4; m += 2) begin
      wait_until(ref_cyc + 24 * m - 3);
      sync_in = 1'b1;
      repeat (10) @(posedge clk);
      #1 sync_in = 1'b0;
    end
    wait_until(ref_cyc + 6 * 24 + 4);
    check_run("R9 aligned sync", "R9 aligned sync");
  endtask

  // R10: sync_in tied high through reset
  task automatic t_tied();
    sync_in = 1'b1;
    do_reset(5, 4, 1'b0, 1'b0);
    wait_until(ref_cyc + 5 * 20 + 4);
    check_run("R10 tied high", "R10 tied high");
    sync_in = 1'b0;
  endtask

  initial begin
    t_reset_levels(1'b1);
    t_reset_levels(1'b0);
    t_mode(2, 5,   1'b1, 1'b1, 4, "R1 R2 n2", "R3 R4 R7 n2 long");
    t_mode(3, 5,   1'b1, 1'b1, 4, "R1 R2 n3", "R3 R4 R7 n3 long");
    t_mode(4, 193, 1'b1, 1'b1, 2, "R1 R2 n4", "R3 R4 n4 long");
    t_mode(5, 5,   1'b1, 1'b1, 4, "R1 R2 n5", "R3 R4 n5 long");
    t_mode(2, 5,   1'b0, 1'b1, 4, "R1 R2 n2", "R3 R5 n2 short");
    t_mode(3, 6,   1'b0, 1'b1, 4, "R1 R2 n3", "R3 R5 n3 short");
    t_mode(4, 5,   1'b0, 1'b1, 4, "R1 R2 n4", "R3 R5 n4 short");
    t_mode(5, 5,   1'b0, 1'b1, 4, "R1 R2 n5", "R3 R5 n5 short");
    t_mode(3, 5,   1'b1, 1'b0, 4, "R1 R2 n3 low", "R6 R4 active low");
    t_realign();
    t_match();
    t_tied();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule